// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This block sits between a synchronous serial shift engine and the register bus. It holds one transmit queue and one receive queue, each 16 entries deep by default. From their occupancy, the enable input, two threshold inputs and the engine's busy flag it builds the 32-bit status word that software reads. It also drives a service-request line for each direction and an overrun interrupt.

Software, or a DMA agent, fills the transmit queue through its push port and the shift engine drains it. The engine fills the receive queue and software drains it. The two level fields are only 4 bits wide, so a full queue and an empty queue report the same code. Each queue therefore has a companion flag that tells the two cases apart: transmit-not-full for the transmit side and receive-not-empty for the receive side.

The overrun flag is the only writable field. It stays set until software writes a 1 to its bit.

Top module: `ssp_fifo_status`

## Requirements
- R1: `status_q` bits 1:0 and bits 31:16 always read 0.
- R2: Bit 2 (transmit-not-full) is 1 unless the transmit queue holds exactly DEPTH entries. Bits 11:8 give the transmit entry count modulo 16.
- R3: Bit 3 (receive-not-empty) is 1 when the receive queue holds at least one entry. Bits 15:12 give the receive entry count minus one, modulo 16, so an empty queue reads 0xF.
- R4: Bit 4 (busy) equals `busy_in` while `enable` is high, and reads 0 while `enable` is low.
- R5: Bit 5 and `tx_req` are 1 exactly when `enable` is high and the transmit count is less than or equal to `tx_thresh`.
- R6: Bit 6 and `rx_req` are 1 exactly when `enable` is high and the receive count is at least `rx_thresh` + 1. The threshold is coded as a count minus one.
- R7: A receive push while the receive queue is full sets bit 7 on the next cycle, unless a pop happens in the same cycle. That push's data is discarded.
- R8: Bit 7 and `ror_irq` hold their value until a register write with `reg_wdata[7]` = 1 clears them. A set in the same cycle wins over the clear. Written values in every other bit have no effect.
- R9: While `enable` is low, both queues are emptied on each clock and pushes are ignored. The overrun flag keeps its value.
- R10: Each queue returns data in push order. A pop from an empty queue is ignored. A transmit push into a full queue is dropped unless a pop happens in the same cycle. `tx_rdata` and `rx_rdata` show the oldest entry, or 0 when the queue is empty.
- R11: After reset, with all inputs low, `status_q` reads 0x0000F004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low flushes both queues |
| busy_in | input | 1 | Shift engine is moving a frame |
| tx_thresh | input | 4 | Transmit service threshold (count) |
| rx_thresh | input | 4 | Receive service threshold (count minus one) |
| tx_push | input | 1 | Write one word into the transmit queue |
| tx_wdata | input | DATA_W | Transmit push data |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| tx_rdata | output | DATA_W | Oldest transmit word |
| rx_push | input | 1 | Engine delivers one received word |
| rx_wdata | input | DATA_W | Receive push data |
| rx_pop | input | 1 | Software takes the oldest received word |
| rx_rdata | output | DATA_W | Oldest received word |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data; bit 7 clears overrun |
| status_q | output | 32 | Packed status word |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| ror_irq | output | 1 | Overrun interrupt |

## Verification
The hardest state to reach is a full receive queue that takes a push while a pop, a clear write or a disable lands in the same cycle. Random traffic rarely holds the queue at 16 entries long enough to get there. The stimulus handles this in two ways. Directed sequences fill the receive queue to the top and then try each same-cycle combination. The random phase is biased toward pushes, so the queues spend long stretches near full, where the aliased level codes and the threshold edges are exercised against changing thresholds.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   localparam int STAT_W    = 32;
   localparam int LVL_FIELD = 4;
   // bit positions of the packed status word
   localparam int B_TNF  = 2;
   localparam int B_RNE  = 3;
   localparam int B_BSY  = 4;
   localparam int B_TREQ = 5;
   localparam int B_RREQ = 6;
   localparam int B_ROR  = 7;
   localparam int B_TLVL = 8;
   localparam int B_RLVL = 12;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
   parameter int W             = 16,
   parameter int DEPTH         = 16,
   parameter bit ZERO_ON_EMPTY = 1'b1,
   localparam int AW           = $clog2(DEPTH),
   localparam int CW           = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          drop
);
   generate
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("sfs_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, empty, do_pop, do_push;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_pop  = pop && !empty && !flush;
   assign do_push = push && !flush && (!full || do_pop);
   assign drop    = push && !flush && full && !do_pop;
   assign count   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   generate
      if (ZERO_ON_EMPTY) begin : g_rd_zero
         assign rdata = empty ? '0 : mem[rp];
      end else begin : g_rd_raw
         assign rdata = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/sfs_stat.sv
module sfs_stat
   import sfs_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic                 enable,
   input  logic                 busy_in,
   input  logic [CW-1:0]        tx_cnt,
   input  logic [CW-1:0]        rx_cnt,
   input  logic [LVL_FIELD-1:0] tx_thresh,
   input  logic [LVL_FIELD-1:0] rx_thresh,
   input  logic                 ror,
   output logic [STAT_W-1:0]    word,
   output logic                 tx_req,
   output logic                 rx_req
);
   localparam int XW = (CW > LVL_FIELD + 1) ? CW : LVL_FIELD + 1;

   logic [XW-1:0]        tx_ext, rx_ext, rx_need;
   logic [LVL_FIELD-1:0] tx_lvl, rx_lvl;
   logic [CW-1:0]        rx_m1;

   assign tx_ext  = XW'(tx_cnt);
   assign rx_ext  = XW'(rx_cnt);
   assign rx_need = XW'(rx_thresh) + XW'(1);
   assign rx_m1   = rx_cnt - 1'b1;

   generate
      if (CW - 1 >= LVL_FIELD) begin : g_lvl_trunc
         assign tx_lvl = tx_cnt[LVL_FIELD-1:0];
         assign rx_lvl = rx_m1[LVL_FIELD-1:0];
      end else begin : g_lvl_pad
         assign tx_lvl = LVL_FIELD'(tx_cnt[CW-2:0]);
         assign rx_lvl = (rx_cnt == '0) ? '1 : LVL_FIELD'(rx_m1[CW-2:0]);
      end
   endgenerate

   assign tx_req = enable && (tx_ext <= XW'(tx_thresh));
   assign rx_req = enable && (rx_ext >= rx_need);

   always_comb begin
      word                            = '0;
      word[B_TNF]                     = (tx_cnt != CW'(DEPTH));
      word[B_RNE]                     = (rx_cnt != '0);
      word[B_BSY]                     = enable && busy_in;
      word[B_TREQ]                    = tx_req;
      word[B_RREQ]                    = rx_req;
      word[B_ROR]                     = ror;
      word[B_TLVL +: LVL_FIELD]       = tx_lvl;
      word[B_RLVL +: LVL_FIELD]       = rx_lvl;
   end
endmodule

// File: rtl/ssp_fifo_status.sv
module ssp_fifo_status
   import sfs_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int DEPTH         = 16,
   parameter bit ZERO_ON_EMPTY = 1'b1,
   localparam int CW           = $clog2(DEPTH) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 busy_in,
   input  logic [LVL_FIELD-1:0] tx_thresh,
   input  logic [LVL_FIELD-1:0] rx_thresh,
   input  logic                 tx_push,
   input  logic [DATA_W-1:0]    tx_wdata,
   input  logic                 tx_pop,
   output logic [DATA_W-1:0]    tx_rdata,
   input  logic                 rx_push,
   input  logic [DATA_W-1:0]    rx_wdata,
   input  logic                 rx_pop,
   output logic [DATA_W-1:0]    rx_rdata,
   input  logic                 reg_wr,
   input  logic [STAT_W-1:0]    reg_wdata,
   output logic [STAT_W-1:0]    status_q,
   output logic                 tx_req,
   output logic                 rx_req,
   output logic                 ror_irq
);
   generate
      if (DEPTH > 16) begin : g_bad_cfg
         $error("ssp_fifo_status: DEPTH above 16 does not fit the level fields");
      end
   endgenerate

   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_drop, rx_drop, ror_q, flush;

   assign flush = !enable;

   sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH), .ZERO_ON_EMPTY(ZERO_ON_EMPTY)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_rdata), .count(tx_cnt), .drop(tx_drop)
   );

   sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH), .ZERO_ON_EMPTY(ZERO_ON_EMPTY)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
      .rdata(rx_rdata), .count(rx_cnt), .drop(rx_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ror_q <= 1'b0;
      else if (rx_drop)                 ror_q <= 1'b1;
      else if (reg_wr && reg_wdata[B_ROR]) ror_q <= 1'b0;
   end

   sfs_stat #(.DEPTH(DEPTH)) u_stat (
      .enable(enable), .busy_in(busy_in),
      .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .ror(ror_q), .word(status_q),
      .tx_req(tx_req), .rx_req(rx_req)
   );

   assign ror_irq = ror_q;
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk
   import sfs_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              busy_in,
   input logic              rx_push,
   input logic              rx_pop,
   input logic              reg_wr,
   input logic [STAT_W-1:0] reg_wdata,
   input logic [STAT_W-1:0] status_q,
   input logic              tx_req,
   input logic              rx_req,
   input logic              ror_irq
);
   logic rx_full;
   assign rx_full = status_q[B_RNE] &&
                    (status_q[B_RLVL +: LVL_FIELD] == LVL_FIELD'(DEPTH - 1));

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[31:16] == '0 && status_q[1:0] == '0);

   // R4
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[B_BSY] |-> (enable && busy_in));

   // R5
   req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!tx_req && !rx_req));

   // R7
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_push && !rx_pop && rx_full) |=> ror_irq);

   // R8
   overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ror_irq && !(reg_wr && reg_wdata[B_ROR])) |=> ror_irq);

   // R9
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (status_q[B_TNF] && !status_q[B_RNE] &&
                   status_q[B_TLVL +: LVL_FIELD] == '0));
endmodule

bind ssp_fifo_status sfs_chk #(.DEPTH(DEPTH)) u_sfs_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .busy_in(busy_in),
   .rx_push(rx_push), .rx_pop(rx_pop), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .status_q(status_q), .tx_req(tx_req),
   .rx_req(rx_req), .ror_irq(ror_irq)
);

// File: tb/tb_ssp_fifo_status.sv
`timescale 1ns/1ps
module tb_ssp_fifo_status;
   localparam int DW = 16;
   localparam int D  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0, busy_in = 1'b0;
   logic [3:0]    tx_thresh = '0, rx_thresh = '0;
   logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [DW-1:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0, status_q;
   logic          tx_req, rx_req, ror_irq;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   logic ror_m = 1'b0;

   always #2.5 clk = ~clk;

   ssp_fifo_status dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .busy_in(busy_in),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .status_q(status_q),
      .tx_req(tx_req), .rx_req(rx_req), .ror_irq(ror_irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      s[2]     = (txq.size() < D);
      s[3]     = (rxq.size() > 0);
      s[4]     = enable && busy_in;
      s[5]     = enable && (txq.size() <= int'(tx_thresh));
      s[6]     = enable && (rxq.size() >= int'(rx_thresh) + 1);
      s[7]     = ror_m;
      s[11:8]  = 4'(txq.size() % 16);
      s[15:12] = 4'((rxq.size() + 15) % 16);
      return s;
   endfunction

   task automatic check_all();
      logic [31:0] e = exp_status();
      chk("R1 reserved",   {status_q[31:16], 14'b0, status_q[1:0]}, '0);
      chk("R2 tx fields",  {status_q[11:8], status_q[2]}, {e[11:8], e[2]});
      chk("R3 rx fields",  {status_q[15:12], status_q[3]}, {e[15:12], e[3]});
      chk("R4 busy",       status_q[4], e[4]);
      chk("R5 tx request", {status_q[5], tx_req}, {e[5], e[5]});
      chk("R6 rx request", {status_q[6], rx_req}, {e[6], e[6]});
      chk("R8 overrun",    {status_q[7], ror_irq}, {e[7], e[7]});
      chk("R10 tx head",   tx_rdata, (txq.size() > 0) ? txq[0] : '0);
      chk("R10 rx head",   rx_rdata, (rxq.size() > 0) ? rxq[0] : '0);
   endtask

   task automatic step(input logic en, input logic tp, input logic tpp,
                       input logic rp, input logic rpp,
                       input logic wr, input logic [31:0] wd);
      bit popped, set;
      @(negedge clk);
      enable = en; tx_push = tp; tx_pop = tpp; rx_push = rp; rx_pop = rpp;
      reg_wr = wr; reg_wdata = wd;
      tx_wdata = DW'($urandom); rx_wdata = DW'($urandom);
      #1;
      check_all();
      @(posedge clk);
      set = 1'b0;
      if (!en) begin
         txq.delete(); rxq.delete();
      end else begin
         popped = tpp && txq.size() > 0;
         if (popped) void'(txq.pop_front());
         if (tp && (txq.size() < D)) txq.push_back(tx_wdata);
         popped = rpp && rxq.size() > 0;
         if (rp && rxq.size() == D && !popped) set = 1'b1;
         if (popped) void'(rxq.pop_front());
         if (rp && !set) rxq.push_back(rx_wdata);
      end
      if (set) ror_m = 1'b1;
      else if (wr && wd[7]) ror_m = 1'b0;
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0123));
      #12 rst_n = 1'b1;
      @(negedge clk); #1;
      // R11 reset word with everything idle
      chk("R11 reset word", status_q, 32'h0000_F004);
      chk("R11 reset irq", {tx_req, rx_req, ror_irq}, 3'b000);

      // R2 R10: fill transmit queue past full, thresholds at edge
      tx_thresh = 4'd3; rx_thresh = 4'd15;
      for (int i = 0; i < D + 2; i++) step(1, 1, 0, 0, 0, 0, 0);
      step(1, 1, 1, 0, 0, 0, 0);                 // push with pop at full
      for (int i = 0; i < D + 1; i++) step(1, 0, 1, 0, 0, 0, 0);

      // R3 R6 R7: fill receive queue, then overrun with and without pop
      for (int i = 0; i < D; i++) step(1, 0, 0, 1, 0, 0, 0);
      step(1, 0, 0, 1, 1, 0, 0);                 // pop saves the push
      step(1, 0, 0, 1, 0, 0, 0);                 // overrun
      step(1, 0, 0, 0, 0, 1, 32'hFFFF_FF7F);     // R8 other bits ignored
      step(1, 0, 0, 1, 0, 1, 32'h0000_0080);     // R8 set beats clear
      step(1, 0, 0, 0, 0, 1, 32'h0000_0080);     // R8 clear
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 1, 0, 0, 0);                 // overrun again

      // R9: disable keeps overrun, flushes, blocks pushes; R4 busy gate
      busy_in = 1'b1;
      step(0, 1, 0, 1, 0, 0, 0);
      step(0, 1, 0, 1, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 1, 0, 1, 0, 0);                 // R10 pop on empty
      step(1, 0, 0, 0, 0, 1, 32'h0000_0080);

      // random phase biased toward pushes
      for (int i = 0; i < 4000; i++) begin
         automatic int r = int'($urandom % 100);
         busy_in   = $urandom % 2 == 1;
         tx_thresh = 4'($urandom);
         rx_thresh = 4'($urandom);
         step(r >= 3,
              ($urandom % 100) < 60, ($urandom % 100) < 40,
              ($urandom % 100) < 60, ($urandom % 100) < 40,
              ($urandom % 100) < 8, 32'($urandom));
      end
      step(1, 0, 0, 0, 0, 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule